// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block serves one bus-master disk channel. Software places a table of 8-byte descriptors in host memory. Each descriptor names a memory region by a 32-bit start address and a size word. The walker is told where the table starts, how many bytes the current transfer needs, and which way the data flows. It then cuts that byte count into chunks that each fit inside one region. It hands every chunk to an external data mover as an (address, length, direction) request.

Descriptors are read one 32-bit word at a time through a simple memory-read port. The walker has only one memory or mover request open at a time. A walk ends in one of two ways. The normal way is when the requested bytes have all been handed out. The other way is when the table runs out first, either because a descriptor was flagged as the final one or because the pointer has drifted a full page past the table start. In that case a short-table status is raised. A walk can be launched fresh, which rewinds to the table start, or resumed, which keeps the partly used region and the pointer from the previous walk.

Top module: `sg_table_walker`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `mv_req` are all low.
- R2: A descriptor is read as two word requests. The region address is read at the pointer, and the size word is read at the pointer plus 4. The pointer then advances by 8. `mem_req` and `mem_addr` hold until `mem_rvalid`, and a memory request and a mover request are never open at the same time.
- R3: The region byte count is size-word bits 15:1 followed by a zero bit 0, so size-word bit 0 has no effect on any chunk length.
- R4: A size word whose bits 15:1 are all zero describes a region of 65536 bytes.
- R5: Size-word bit 31 set marks the final descriptor. Once that region is used up, no further descriptor is read.
- R6: A descriptor is read only when the current region has no bytes left. A resumed walk first spends what remains of the current region.
- R7: When a new descriptor is needed and the pointer is PAGE_BYTES or more past the table start, the walk ends without reading it.
- R8: Each mover request carries the smaller of the bytes still requested and the bytes left in the region. Its address is the region's current address, which advances by each chunk. `mv_dir` equals `is_write` as it was at launch. The request holds stable until `mv_ack`.
- R9: `start` clears the current region state and reloads the pointer from `table_base`. `resume` keeps both.
- R10: `done` is a one-cycle pulse at the end of every walk. `short_tbl` is 1 if the table ended before the requested count was met and 0 otherwise. It stays valid until the next launch.
- R11: A launch with `xfer_len` of 0 pulses `done` on the following cycle, with no memory read and no mover request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a fresh walk from the table start (taken when idle) |
| resume | input | 1 | Launch a walk that continues the previous region (taken when idle) |
| xfer_len | input | LEN_W | Bytes requested for this walk |
| is_write | input | 1 | Transfer direction for this walk |
| table_base | input | ADDR_W | Byte address of the first descriptor (word aligned) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | ADDR_W | Byte address of the word being read |
| mem_rvalid | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 32 | Read data word |
| mv_req | output | 1 | Data mover chunk request |
| mv_addr | output | ADDR_W | Chunk start address |
| mv_len | output | CNT_W+1 | Chunk length in bytes |
| mv_dir | output | 1 | Chunk direction |
| mv_ack | input | 1 | Data mover accepts and completes the chunk |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| short_tbl | output | 1 | Table ended before the request was met |

## Verification
The bench builds the walker with PAGE_BYTES set to 64. At that value the page fail-safe trips after eight descriptors, so an unterminated table reaches the overrun stop within a short run. The field widths stay at their defaults (16-bit count field, 20-bit request), so the 65536-byte zero-count region and the masking of bit 0 are exercised with their real encodings. Request lengths are swept in small steps across three-descriptor and nine-descriptor tables. A chained sequence of resumed walks checks region carry-over, and fresh launches check rewinding.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  // Bit of the size word that flags the final descriptor.
  localparam int LAST_BIT = 31;
  // Word width of the descriptor memory port.
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_FETCH_ADDR = 3'd1,
    ST_FETCH_SIZE = 3'd2,
    ST_MOVE       = 3'd3,
    ST_DONE       = 3'd4
  } sgw_state_e;
endpackage

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode
  import sgw_pkg::*;
#(
  parameter int CNT_W  = 16,
  localparam int RLEN_W = CNT_W + 1
) (
  input  logic [WORD_W-1:0] size_word,
  output logic [RLEN_W-1:0] region_len,
  output logic              region_last
);
  logic [CNT_W-2:0]          count_field;
  logic [WORD_W-CNT_W-2:0]   unused_bits;
  logic                      unused_lsb;

  assign count_field = size_word[CNT_W-1:1];
  assign unused_bits = size_word[LAST_BIT-1:CNT_W];
  assign unused_lsb  = size_word[0];

  // Bit 0 is dropped; an all-zero count field stands for the full range.
  always_comb begin
    if (count_field == '0) begin
      region_len = {1'b1, {CNT_W{1'b0}}};
    end else begin
      region_len = {1'b0, count_field, 1'b0};
    end
  end

  assign region_last = size_word[LAST_BIT];
endmodule

// File: rtl/sgw_chunk_sel.sv
module sgw_chunk_sel #(
  parameter int LEN_W  = 20,
  parameter int RLEN_W = 17
) (
  input  logic [LEN_W-1:0]  req_left,
  input  logic [RLEN_W-1:0] region_left,
  output logic [RLEN_W-1:0] chunk_len
);
  logic [LEN_W-1:0] region_wide;

  assign region_wide = LEN_W'(region_left);

  always_comb begin
    if (req_left >= region_wide) begin
      chunk_len = region_left;
    end else begin
      chunk_len = req_left[RLEN_W-1:0];
    end
  end
endmodule

// File: rtl/sgw_ctrl.sv
module sgw_ctrl
  import sgw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 20,
  parameter int RLEN_W     = 17,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              resume,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] table_base,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [RLEN_W-1:0] dec_len,
  input  logic              dec_last,
  output logic [LEN_W-1:0]  req_left,
  output logic [RLEN_W-1:0] region_left,
  input  logic [RLEN_W-1:0] chunk_len,
  output logic              mv_req,
  output logic [ADDR_W-1:0] mv_addr,
  output logic [RLEN_W-1:0] mv_len,
  output logic              mv_dir,
  input  logic              mv_ack,
  output logic              busy,
  output logic              done,
  output logic              short_tbl
);
  localparam logic [ADDR_W-1:0] PAGE_LIM  = ADDR_W'(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] DESC_STEP = ADDR_W'(8);

  sgw_state_e        state_q, state_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] raddr_q, raddr_d;
  logic [RLEN_W-1:0] rlen_q, rlen_d;
  logic              last_q, last_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              dir_q, dir_d;
  logic              short_q, short_d;
  logic              table_end;
  logic              final_chunk;
  logic              launch;

  // No further descriptor may be read: flagged end or page fail-safe.
  assign table_end   = last_q || ((ptr_q - base_q) >= PAGE_LIM);
  assign final_chunk = (rem_q == LEN_W'(chunk_len));
  assign launch      = start || resume;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    ptr_d   = ptr_q;
    raddr_d = raddr_q;
    rlen_d  = rlen_q;
    last_d  = last_q;
    rem_d   = rem_q;
    dir_d   = dir_q;
    short_d = short_q;
    unique case (state_q)
      ST_IDLE: begin
        if (launch) begin
          rem_d   = xfer_len;
          dir_d   = is_write;
          short_d = 1'b0;
          if (start) begin
            base_d  = table_base;
            ptr_d   = table_base;
            raddr_d = '0;
            rlen_d  = '0;
            last_d  = 1'b0;
            state_d = (xfer_len == '0) ? ST_DONE : ST_FETCH_ADDR;
          end else if (xfer_len == '0) begin
            state_d = ST_DONE;
          end else if (rlen_q != '0) begin
            state_d = ST_MOVE;
          end else if (table_end) begin
            short_d = 1'b1;
            state_d = ST_DONE;
          end else begin
            state_d = ST_FETCH_ADDR;
          end
        end
      end
      ST_FETCH_ADDR: begin
        if (mem_rvalid) begin
          raddr_d = mem_rdata[ADDR_W-1:0];
          state_d = ST_FETCH_SIZE;
        end
      end
      ST_FETCH_SIZE: begin
        if (mem_rvalid) begin
          rlen_d  = dec_len;
          last_d  = dec_last;
          ptr_d   = ptr_q + DESC_STEP;
          state_d = ST_MOVE;
        end
      end
      ST_MOVE: begin
        if (mv_ack) begin
          raddr_d = raddr_q + ADDR_W'(chunk_len);
          rlen_d  = rlen_q - chunk_len;
          rem_d   = rem_q - LEN_W'(chunk_len);
          if (final_chunk) begin
            state_d = ST_DONE;
          end else if (table_end) begin
            short_d = 1'b1;
            state_d = ST_DONE;
          end else begin
            state_d = ST_FETCH_ADDR;
          end
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      ptr_q   <= '0;
      raddr_q <= '0;
      rlen_q  <= '0;
      last_q  <= 1'b0;
      rem_q   <= '0;
      dir_q   <= 1'b0;
      short_q <= 1'b0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      ptr_q   <= ptr_d;
      raddr_q <= raddr_d;
      rlen_q  <= rlen_d;
      last_q  <= last_d;
      rem_q   <= rem_d;
      dir_q   <= dir_d;
      short_q <= short_d;
    end
  end

  // Outputs
  always_comb begin
    mem_req = 1'b0;
    mem_addr = ptr_q;
    if (state_q == ST_FETCH_ADDR) begin
      mem_req = 1'b1;
    end else if (state_q == ST_FETCH_SIZE) begin
      mem_req  = 1'b1;
      mem_addr = ptr_q + WORD_STEP;
    end
  end

  assign req_left    = rem_q;
  assign region_left = rlen_q;
  assign mv_req      = (state_q == ST_MOVE);
  assign mv_addr     = raddr_q;
  assign mv_len      = chunk_len;
  assign mv_dir      = dir_q;
  assign busy        = (state_q != ST_IDLE);
  assign done        = (state_q == ST_DONE);
  assign short_tbl   = short_q;
endmodule

// File: rtl/sg_table_walker.sv
module sg_table_walker
  import sgw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 20,
  parameter int CNT_W      = 16,
  parameter int PAGE_BYTES = 4096,
  localparam int RLEN_W    = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              resume,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] table_base,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mv_req,
  output logic [ADDR_W-1:0] mv_addr,
  output logic [RLEN_W-1:0] mv_len,
  output logic              mv_dir,
  input  logic              mv_ack,
  output logic              busy,
  output logic              done,
  output logic              short_tbl
);
  logic [RLEN_W-1:0] dec_len;
  logic              dec_last;
  logic [LEN_W-1:0]  req_left;
  logic [RLEN_W-1:0] region_left;
  logic [RLEN_W-1:0] chunk_len;

  sgw_desc_decode #(.CNT_W(CNT_W)) u_decode (
    .size_word   (mem_rdata),
    .region_len  (dec_len),
    .region_last (dec_last)
  );

  sgw_chunk_sel #(.LEN_W(LEN_W), .RLEN_W(RLEN_W)) u_chunk (
    .req_left    (req_left),
    .region_left (region_left),
    .chunk_len   (chunk_len)
  );

  sgw_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .RLEN_W(RLEN_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .resume      (resume),
    .xfer_len    (xfer_len),
    .is_write    (is_write),
    .table_base  (table_base),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .dec_len     (dec_len),
    .dec_last    (dec_last),
    .req_left    (req_left),
    .region_left (region_left),
    .chunk_len   (chunk_len),
    .mv_req      (mv_req),
    .mv_addr     (mv_addr),
    .mv_len      (mv_len),
    .mv_dir      (mv_dir),
    .mv_ack      (mv_ack),
    .busy        (busy),
    .done        (done),
    .short_tbl   (short_tbl)
  );
endmodule

// File: rtl/sgw_walker_chk.sv
module sgw_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 20,
  parameter int CNT_W  = 16,
  localparam int RLEN_W = CNT_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              resume,
  input logic [LEN_W-1:0]  xfer_len,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              mv_req,
  input logic [ADDR_W-1:0] mv_addr,
  input logic [RLEN_W-1:0] mv_len,
  input logic              mv_ack,
  input logic              busy,
  input logic              done
);
  localparam logic [RLEN_W-1:0] MAX_REGION = {1'b1, {CNT_W{1'b0}}};

  // Toggles on each completed word read: 0 = address word next, 1 = size word next.
  logic word_phase;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_phase <= 1'b0;
    end else if (mem_req && mem_rvalid) begin
      word_phase <= ~word_phase;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !mv_req));

  // R2
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mv_req));

  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R2
  size_word_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid && !word_phase) |=>
      (mem_req && (mem_addr == $past(mem_addr) + ADDR_W'(4))));

  // R8
  mv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_req && !mv_ack) |=> (mv_req && $stable(mv_addr) && $stable(mv_len)));

  // R8
  mv_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_req |-> ((mv_len != '0) && (mv_len <= MAX_REGION)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (start || resume) && (xfer_len == '0)) |=> (done && !mem_req && !mv_req));
endmodule

bind sg_table_walker sgw_walker_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
) u_walker_chk (.*);

// File: tb/sg_table_walker_test.sv
module sg_table_walker_test;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 20;
  localparam int CNT_W  = 16;
  localparam int PAGE   = 64;
  localparam int BASE   = 'h100;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic              resume;
  logic [LEN_W-1:0]  xfer_len;
  logic              is_write;
  logic [ADDR_W-1:0] table_base;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rvalid;
  logic [31:0]       mem_rdata;
  logic              mv_req;
  logic [ADDR_W-1:0] mv_addr;
  logic [CNT_W:0]    mv_len;
  logic              mv_dir;
  logic              mv_ack;
  logic              busy;
  logic              done;
  logic              short_tbl;

  sg_table_walker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE)
  ) uut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] mem [0:1023];

  // Logs filled by the models
  longint got_addr [0:255];
  longint got_len  [0:255];
  bit     got_dir  [0:255];
  int     n_got;
  int     got_fetch;
  bit     done_seen;
  bit     got_short;

  // Reference model state
  longint exp_addr [0:255];
  longint exp_len  [0:255];
  int     n_exp;
  int     exp_fetch;
  bit     exp_short;
  int     r_ptr;
  longint r_raddr;
  longint r_rlen;
  bit     r_last;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic put_desc(input int k, input logic [31:0] a, input logic [31:0] s);
    mem[(BASE + 8*k) >> 2]     = a;
    mem[(BASE + 8*k + 4) >> 2] = s;
  endtask

  task automatic clear_table();
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
  endtask

  // Reference walk computed from the requirements
  task automatic ref_walk(input bit fresh, input int req);
    logic [31:0] a;
    logic [31:0] s;
    longint cnt;
    longint c;
    longint left;
    n_exp = 0; exp_fetch = 0; exp_short = 0;
    left = req;
    if (fresh) begin
      r_ptr = 0; r_raddr = 0; r_rlen = 0; r_last = 0;
    end
    while (left > 0) begin
      if (r_rlen == 0) begin
        if (r_last || r_ptr >= PAGE) begin
          exp_short = 1;
          break;
        end
        a = mem[(BASE + r_ptr) >> 2];
        s = mem[(BASE + r_ptr + 4) >> 2];
        r_ptr += 8;
        exp_fetch += 2;
        cnt = longint'(s & 32'h0000_fffe);
        if (cnt == 0) cnt = 65536;
        r_rlen = cnt; r_raddr = longint'(a); r_last = s[31];
      end
      c = (left < r_rlen) ? left : r_rlen;
      exp_addr[n_exp] = r_raddr;
      exp_len[n_exp]  = c;
      n_exp++;
      r_raddr += c; r_rlen -= c; left -= c;
    end
  endtask

  // Memory model: variable latency, one word per request
  int mem_lat = 0;
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = 32'h0;
    forever begin
      @(negedge clk);
      if (mem_rvalid) begin
        mem_rvalid = 1'b0;
      end else if (mem_req) begin
        if (mem_lat > 0) begin
          mem_lat--;
        end else begin
          mem_rdata  = mem[mem_addr[11:2]];
          mem_rvalid = 1'b1;
          got_fetch++;
          mem_lat = got_fetch % 3;
        end
      end
    end
  end

  // Data mover model
  int mv_dly = 0;
  initial begin
    mv_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (mv_ack) begin
        mv_ack = 1'b0;
      end else if (mv_req) begin
        if (mv_dly > 0) begin
          mv_dly--;
        end else begin
          if (n_got < 256) begin
            got_addr[n_got] = longint'(mv_addr);
            got_len[n_got]  = longint'(mv_len);
            got_dir[n_got]  = mv_dir;
          end
          n_got++;
          mv_ack = 1'b1;
          mv_dly = n_got % 2;
        end
      end
    end
  end

  // Done monitor
  initial begin
    done_seen = 0;
    got_short = 0;
    forever begin
      @(negedge clk);
      if (done) begin
        done_seen = 1;
        got_short = short_tbl;
      end
    end
  end

  // Launch one walk and compare against the reference
  task automatic run(input bit fresh, input int len, input bit wr, input string tag);
    ref_walk(fresh, len);
    @(negedge clk);
    n_got = 0; got_fetch = 0; done_seen = 0;
    start = fresh; resume = !fresh;
    xfer_len = LEN_W'(len); is_write = wr;
    @(negedge clk);
    start = 0; resume = 0;
    while (!done_seen) @(negedge clk);
    chk(n_got == n_exp, tag, "chunk count", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      chk(got_addr[i] == exp_addr[i], tag, "chunk address", got_addr[i], exp_addr[i]);
      chk(got_len[i] == exp_len[i], tag, "chunk length", got_len[i], exp_len[i]);
      chk(got_dir[i] == wr, "R8", "chunk direction", got_dir[i], wr);
    end
    chk(got_fetch == exp_fetch, tag, "descriptor words read", got_fetch, exp_fetch);
    chk(got_short == exp_short, "R10", "short-table flag", got_short, exp_short);
    @(negedge clk);
    chk(!busy, "R10", "idle after done", busy, 0);
  endtask

  initial begin
    rst_n = 0; start = 0; resume = 0; xfer_len = '0; is_write = 0;
    table_base = ADDR_W'(BASE);
    n_got = 0; got_fetch = 0;
    clear_table();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_req && !mv_req, "R1", "outputs in reset",
        {busy, done, mem_req, mv_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !mem_req && !mv_req, "R1", "outputs after reset",
        {busy, done, mem_req, mv_req}, 0);

    // R2 / R5: single final descriptor, exact and oversize requests
    put_desc(0, 32'h0000_1000, 32'h8000_0100);
    run(1, 'h100, 0, "R2");
    run(1, 'h12c, 1, "R5");
    chk(got_short == 1, "R5", "short on final descriptor", got_short, 1);

    // R3: size bit 0 ignored (0x103 describes 0x102 bytes)
    put_desc(0, 32'h0000_2000, 32'h8000_0103);
    run(1, 'h102, 0, "R3");
    run(1, 'h104, 1, "R3");
    chk(n_got == 1 && got_len[0] == 'h102, "R3", "masked length", got_len[0], 'h102);

    // R4: zero count field means 65536 bytes (bit 0 set still zero)
    put_desc(0, 32'h0001_0000, 32'h8000_0001);
    run(1, 65536, 0, "R4");
    chk(got_len[0] == 65536, "R4", "full-range region", got_len[0], 65536);

    // R11: zero request length
    run(1, 0, 1, "R11");
    chk(n_got == 0 && got_fetch == 0 && got_short == 0, "R11", "no activity",
        n_got + got_fetch, 0);

    // R8: three-descriptor table, sweep of request lengths
    clear_table();
    put_desc(0, 32'h0000_2000, 32'h0000_0040);
    put_desc(1, 32'h0000_3000, 32'h0000_0023);
    put_desc(2, 32'h0000_4000, 32'h8000_0010);
    put_desc(3, 32'h0000_5000, 32'h0000_0100);
    for (int len = 0; len <= 'h90; len += 2) begin
      run(1, len, len[1], "R8");
    end

    // R6 / R9: resumed walks continue the region, fresh walk rewinds
    run(1, 'h20, 0, "R6");
    run(0, 'h30, 1, "R6");
    chk(got_addr[0] == 'h2020, "R6", "resume continues region", got_addr[0], 'h2020);
    run(0, 'h14, 0, "R6");
    run(0, 'h20, 0, "R9");
    chk(got_short == 1 && n_got == 1, "R9", "resume hits final descriptor", got_short, 1);
    run(0, 'h10, 0, "R9");
    chk(got_short == 1 && n_got == 0, "R9", "resume after table end", n_got, 0);
    run(1, 'h10, 1, "R9");
    chk(got_addr[0] == 'h2000, "R9", "start rewinds to table base", got_addr[0], 'h2000);

    // R7: nine unterminated descriptors, page fail-safe stops at eight
    clear_table();
    for (int k = 0; k < 9; k++) put_desc(k, 32'h0000_8000 + 32'(k * 'h100), 32'h0000_0010);
    for (int len = 2; len <= 'ha0; len += 6) begin
      run(1, len, 0, "R7");
    end
    run(1, 'h200, 1, "R7");
    chk(got_fetch == 16 && got_short == 1, "R7", "fetches before overrun stop", got_fetch, 16);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule